// File: doc/BRIEF.md
# Flash Program/Erase Command Controller

This block sits between a CPU register bus and a flash array and turns register writes into flash operations: a one-word program, a sector erase or a whole-block erase. Programming is guarded twice. A self-program enable bit must be on, and the key register must receive the byte FAh and then the byte F5h. Only then is one operation accepted. The target is a segment number plus an offset within the segment. The word to program comes from the data register, and writing that register starts the program.

While an operation runs, the block holds the CPU with a stall output. The stall stays high for two extra guard cycles after the flash finishes. The flash cell time is modelled by a down-counter whose lengths are parameters. Each accepted operation uses up the unlock, so the next operation needs a new key sequence. An attempt made while locked or while stalled has no effect and sets a sticky error flag, which software clears by writing a 1 to it.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, the block is locked, `cpuStall` is 0 and `flashOp` is 0.
- R2: Register map, selected by `regAddr`:
  - 0 = CTRL. Bit 0 is the enable and bit 1 is the sector select; both are stored and read back. Bit 2 is erase start and reads as 0.
  - 1 = KEY. Written through bits 7:0; reads as 0.
  - 2 = SEG.
  - 3 = ADDR.
  - 4 = DATA. Reads back the last accepted program word.
  - 5 = STAT. Bit 0 = busy, bit 1 = error, bit 2 = unlocked.
- R3: With the enable on, KEY writes of FAh and then F5h set STAT bit 2. Any other byte where a key byte is expected returns to locked. This includes a second FAh, and any KEY write while already unlocked.
- R4: KEY writes made while the enable is 0 are ignored; the block stays locked.
- R5: A CTRL write with bit 0 = 0 returns the block to locked.
- R6: A DATA write while unlocked and not stalled starts a program. From the next cycle, `flashOp` = 1 for PROG_CYC cycles, with `flashSeg`, `flashAddr` and `flashData` equal to the SEG, ADDR and written DATA values.
- R7: A CTRL write with bit 2 = 1 and bit 0 = 1, while unlocked and not stalled, starts an erase for ERASE_CYC cycles. `flashOp` is 2 (sector) if bit 1 of that written value is 1, and 3 (block) otherwise.
- R8: `cpuStall` is high from the cycle after an operation starts, for the operation length plus 2 cycles.
- R9: STAT bit 0 is 1 exactly while `flashOp` is nonzero.
- R10: An accepted operation relocks the block, so a second operation without a new key is rejected.
- R11: A program or erase attempt made while locked or stalled is rejected. It leaves the DATA register, `flashOp` and `cpuStall` unchanged and sets STAT bit 1.
- R12: STAT bit 1 stays set until a STAT write with bit 1 = 1. A STAT write with bit 1 = 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data (combinational) |
| cpuStall | output | 1 | Holds the CPU during an operation and its guard time |
| flashOp | output | 2 | Running operation: 0 none, 1 program, 2 sector erase, 3 block erase |
| flashSeg | output | SEG_W | Target segment |
| flashAddr | output | ADDR_W | Target offset |
| flashData | output | DATA_W | Word being programmed |

## Verification
The bench builds the block with PROG_CYC = 3, ERASE_CYC = 7, SEG_W = 4 and ADDR_W = 6. With these values, every segment and a full sweep of offsets can be programmed and read back in a few thousand cycles. The short busy lengths also make exact stall and busy counting cheap for every operation kind. The key stage is swept over all 256 values of the first byte and all 256 values of the second byte. This proves that only the exact ordered pair unlocks the block.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_KEY  = 3'd1;
  localparam logic [2:0] REG_SEG  = 3'd2;
  localparam logic [2:0] REG_ADDR = 3'd3;
  localparam logic [2:0] REG_DATA = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;

  localparam logic [7:0] KEY_FIRST  = 8'hFA;
  localparam logic [7:0] KEY_SECOND = 8'hF5;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_SECT  = 2'd2,
    OP_BLOCK = 2'd3
  } fpcOp_e;

  // requests decoded by the datapath, consumed by control
  typedef struct packed {
    logic       selfEn;
    logic       enClear;
    logic       keyWr;
    logic [7:0] keyByte;
    logic       progReq;
    logic       eraseReq;
    logic       eraseSect;
  } fpcReq_t;

  // strobes from control to the datapath
  typedef struct packed {
    logic capData;
    logic setErr;
  } fpcStrb_t;
endpackage

// File: rtl/fpc_dpath.sv
module fpc_dpath
  import fpc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEG_W  = 4,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  fpcStrb_t          strb,
  input  logic              busy,
  input  logic              unlocked,
  output fpcReq_t           req,
  output logic [DATA_W-1:0] regRdata,
  output logic [SEG_W-1:0]  segOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut
);
  logic              selfEnQ, sectSelQ, errQ;
  logic [SEG_W-1:0]  segQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              wrCtrl;

  assign wrCtrl = regWe && (regAddr == REG_CTRL);

  always_comb begin
    req.selfEn    = selfEnQ;
    req.enClear   = wrCtrl && !regWdata[0];
    req.keyWr     = regWe && (regAddr == REG_KEY);
    req.keyByte   = regWdata[7:0];
    req.progReq   = regWe && (regAddr == REG_DATA);
    req.eraseReq  = wrCtrl && regWdata[2];
    req.eraseSect = regWdata[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selfEnQ  <= 1'b0;
      sectSelQ <= 1'b0;
      segQ     <= '0;
      addrQ    <= '0;
      dataQ    <= '0;
      errQ     <= 1'b0;
    end else begin
      if (wrCtrl) begin
        selfEnQ  <= regWdata[0];
        sectSelQ <= regWdata[1];
      end
      if (regWe && regAddr == REG_SEG)  segQ  <= regWdata[SEG_W-1:0];
      if (regWe && regAddr == REG_ADDR) addrQ <= regWdata[ADDR_W-1:0];
      if (strb.capData) dataQ <= regWdata;
      if (strb.setErr) errQ <= 1'b1;
      else if (regWe && regAddr == REG_STAT && regWdata[1]) errQ <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_CTRL: begin
        regRdata[0] = selfEnQ;
        regRdata[1] = sectSelQ;
      end
      REG_SEG:  regRdata[SEG_W-1:0]  = segQ;
      REG_ADDR: regRdata[ADDR_W-1:0] = addrQ;
      REG_DATA: regRdata = dataQ;
      REG_STAT: begin
        regRdata[0] = busy;
        regRdata[1] = errQ;
        regRdata[2] = unlocked;
      end
      default: regRdata = '0;
    endcase
  end

  assign segOut  = segQ;
  assign addrOut = addrQ;
  assign dataOut = dataQ;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errQ && !(regWe && regAddr == REG_STAT && regWdata[1]) |=> errQ); // R12
  AST_DATA_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strb.capData |=> $stable(dataQ)); // R11
endmodule

// File: rtl/fpc_ctrl.sv
module fpc_ctrl
  import fpc_pkg::*;
#(
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 400
) (
  input  logic     clk,
  input  logic     rstN,
  input  fpcReq_t  req,
  output fpcStrb_t strb,
  output logic     stall,
  output logic     busy,
  output logic     unlocked,
  output fpcOp_e   flashOp
);
  localparam int GUARD_CYC = 2;
  localparam int MAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_C = (MAX_A > GUARD_CYC) ? MAX_A : GUARD_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] GUARD_LOAD = CNT_W'(GUARD_CYC - 1);

  typedef enum logic [1:0] {UL_LOCK, UL_HALF, UL_OPEN} unlock_e;
  typedef enum logic [1:0] {PH_IDLE, PH_BUSY, PH_GUARD} phase_e;

  unlock_e          ulQ, ulNext;
  phase_e           phQ;
  logic [CNT_W-1:0] cntQ;
  fpcOp_e           opQ;
  logic             attempt, start;

  assign attempt = req.progReq || req.eraseReq;
  assign start   = attempt && (ulQ == UL_OPEN) && (phQ == PH_IDLE) && !req.enClear;

  assign strb.capData = start && req.progReq;
  assign strb.setErr  = attempt && !start;

  always_comb begin
    ulNext = ulQ;
    if (start || req.enClear || !req.selfEn) ulNext = UL_LOCK;
    else if (req.keyWr) begin
      case (ulQ)
        UL_LOCK: ulNext = (req.keyByte == KEY_FIRST)  ? UL_HALF : UL_LOCK;
        UL_HALF: ulNext = (req.keyByte == KEY_SECOND) ? UL_OPEN : UL_LOCK;
        default: ulNext = UL_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ulQ <= UL_LOCK;
    else       ulQ <= ulNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phQ  <= PH_IDLE;
      cntQ <= '0;
      opQ  <= OP_NONE;
    end else begin
      case (phQ)
        PH_IDLE: if (start) begin
          phQ <= PH_BUSY;
          if (req.progReq) begin
            cntQ <= PROG_LOAD;
            opQ  <= OP_PROG;
          end else begin
            cntQ <= ERASE_LOAD;
            opQ  <= req.eraseSect ? OP_SECT : OP_BLOCK;
          end
        end
        PH_BUSY: if (cntQ == '0) begin
          phQ  <= PH_GUARD;
          cntQ <= GUARD_LOAD;
        end else cntQ <= cntQ - 1'b1;
        PH_GUARD: if (cntQ == '0) phQ <= PH_IDLE;
                  else cntQ <= cntQ - 1'b1;
        default: phQ <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (phQ == PH_BUSY);
  assign stall    = (phQ != PH_IDLE);
  assign unlocked = (ulQ == UL_OPEN);
  assign flashOp  = busy ? opQ : OP_NONE;

  AST_KEY_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ulQ == UL_OPEN) |-> $past(ulQ == UL_HALF)); // R3
  AST_LOCKED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !req.selfEn |=> ulQ == UL_LOCK); // R4
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (ulQ == UL_LOCK) && stall); // R10
  AST_GUARD_TWO: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> stall ##1 stall ##1 !stall); // R8
  AST_OP_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(flashOp)); // R11
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fpc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEG_W     = 4,
  parameter int ADDR_W    = 10,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              cpuStall,
  output logic [1:0]        flashOp,
  output logic [SEG_W-1:0]  flashSeg,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashData
);
  fpcReq_t  req;
  fpcStrb_t strb;
  logic     busy, unlocked;
  fpcOp_e   opKind;

  fpc_dpath #(.DATA_W(DATA_W), .SEG_W(SEG_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .strb(strb), .busy(busy), .unlocked(unlocked), .req(req), .regRdata(regRdata),
    .segOut(flashSeg), .addrOut(flashAddr), .dataOut(flashData)
  );

  fpc_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .strb(strb), .stall(cpuStall),
    .busy(busy), .unlocked(unlocked), .flashOp(opKind)
  );

  assign flashOp = opKind;

  AST_BUSY_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (flashOp != 2'd0) == regRdata[0] || regAddr != REG_STAT); // R9
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  localparam int DW = 16, SW = 4, AW = 6, PC = 3, EC = 7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic          cpuStall;
  logic [1:0]    flashOp;
  logic [SW-1:0] flashSeg;
  logic [AW-1:0] flashAddr;
  logic [DW-1:0] flashData;

  int nChk = 0, nBad = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.DATA_W(DW), .SEG_W(SW), .ADDR_W(AW), .PROG_CYC(PC), .ERASE_CYC(EC))
    u_flash_cmd_ctrl (
      .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
      .regRdata(regRdata), .cpuStall(cpuStall), .flashOp(flashOp), .flashSeg(flashSeg),
      .flashAddr(flashAddr), .flashData(flashData)
    );

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'(a); regWdata = DW'(d);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    regAddr = 3'(a);
    #1;
    v = int'(regRdata);
  endtask

  task automatic unlock();
    wr(1, 'hFA);
    wr(1, 'hF5);
  endtask

  task automatic measure(input int expOp, input int n, input int seg, input int adr,
                         input int dat, input string tag);
    int stallN = 0, opN = 0, busyN = 0, v;
    bit first = 1'b1;
    while (cpuStall && stallN < 1000) begin
      rd(5, v);
      if (v & 1) busyN++;
      if (flashOp == 2'(expOp)) opN++;
      if ((v & 1) != int'(flashOp != 0)) check("R9 busy mirror", v & 1, int'(flashOp != 0));
      if (first) begin
        check({tag, " op kind"}, int'(flashOp), expOp);
        if (seg >= 0) begin
          check("R6 flashSeg", int'(flashSeg), seg);
          check("R6 flashAddr", int'(flashAddr), adr);
          check("R6 flashData", int'(flashData), dat);
        end
        first = 1'b0;
      end
      stallN++;
      @(negedge clk);
    end
    check("R8 stall length", stallN, n + 2);
    check({tag, " op length"}, opN, n);
    check("R9 busy length", busyN, n);
  endtask

  initial begin
    #(8 * 200000);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      check("R1 reset readback", v, 0);
    end
    check("R1 stall", int'(cpuStall), 0);
    check("R1 flashOp", int'(flashOp), 0);

    // R2: register map readback sweeps
    for (int s = 0; s < (1 << SW); s++) begin
      wr(2, s); rd(2, v); check("R2 SEG readback", v, s);
    end
    for (int a = 0; a < (1 << AW); a++) begin
      wr(3, a); rd(3, v); check("R2 ADDR readback", v, a);
    end
    wr(0, 3); rd(0, v); check("R2 CTRL readback", v, 3);
    rd(1, v); check("R2 KEY reads 0", v, 0);
    wr(0, 0);

    // R4: keys ignored while disabled
    unlock(); rd(5, v); check("R4 locked when disabled", (v >> 2) & 1, 0);
    wr(0, 1); wr(1, 'hF5); rd(5, v); check("R4 stays locked", (v >> 2) & 1, 0);

    // R3: sweep first key byte
    for (int b = 0; b < 256; b++) begin
      wr(0, 1); wr(1, b); wr(1, 'hF5); rd(5, v);
      check("R3 first byte sweep", (v >> 2) & 1, int'(b == 'hFA));
      wr(0, 0);
    end
    // R3: sweep second key byte
    for (int c = 0; c < 256; c++) begin
      wr(0, 1); wr(1, 'hFA); wr(1, c); rd(5, v);
      check("R3 second byte sweep", (v >> 2) & 1, int'(c == 'hF5));
      wr(0, 0);
    end
    wr(0, 1); wr(1, 'hF5); wr(1, 'hFA); rd(5, v);
    check("R3 reversed order", (v >> 2) & 1, 0);
    wr(0, 0); wr(0, 1); unlock(); wr(1, 'hFA); rd(5, v);
    check("R3 extra key relocks", (v >> 2) & 1, 0);

    // R5: clearing enable relocks
    unlock(); rd(5, v); check("R5 unlocked", (v >> 2) & 1, 1);
    wr(0, 0); wr(0, 1); rd(5, v); check("R5 relocked", (v >> 2) & 1, 0);

    // R6 / R8 / R9 / R10: program sweep over all segments
    for (int s = 0; s < (1 << SW); s++) begin
      int a, d;
      a = (s * 5 + 3) % (1 << AW);
      d = ((s * 'h1111) ^ 'hA5A5) & 'hFFFF;
      wr(0, 1); unlock(); wr(2, s); wr(3, a); wr(4, d);
      measure(1, PC, s, a, d, "R6 program");
      rd(4, v); check("R6 DATA readback", v, d);
      rd(5, v); check("R10 relocked after op", (v >> 2) & 1, 0);
      check("R11 no error", (v >> 1) & 1, 0);
    end

    // R10: second program without key is rejected
    wr(4, 'h0F0F); rd(4, v);
    check("R10 DATA unchanged", v, ((15 * 'h1111) ^ 'hA5A5) & 'hFFFF);
    check("R10 no stall", int'(cpuStall), 0);
    rd(5, v); check("R10 error set", (v >> 1) & 1, 1);

    // R12: clearing the error flag
    wr(5, 0); rd(5, v); check("R12 write 0 keeps error", (v >> 1) & 1, 1);
    wr(5, 2); rd(5, v); check("R12 write 1 clears error", (v >> 1) & 1, 0);

    // R7: erases
    wr(0, 3); unlock(); wr(0, 7);
    measure(2, EC, -1, 0, 0, "R7 sector erase");
    wr(0, 1); unlock(); wr(0, 5);
    measure(3, EC, -1, 0, 0, "R7 block erase");
    wr(0, 3); unlock(); wr(0, 5);
    measure(3, EC, -1, 0, 0, "R7 select cleared gives block");
    rd(5, v); check("R7 no error", (v >> 1) & 1, 0);

    // R11: erase with enable clear, program while locked, program while stalled
    wr(0, 1); unlock(); wr(0, 6);
    check("R11 erase with enable 0 no stall", int'(cpuStall), 0);
    rd(5, v); check("R11 error set", (v >> 1) & 1, 1);
    wr(5, 2);
    wr(0, 1); wr(0, 5);
    check("R11 locked erase no stall", int'(cpuStall), 0);
    check("R11 locked erase no op", int'(flashOp), 0);
    wr(5, 2);
    wr(0, 1); unlock(); wr(4, 'h1357);
    wr(4, 'h2468);
    check("R11 still stalled", int'(cpuStall), 1);
    while (cpuStall) @(negedge clk);
    rd(4, v); check("R11 DATA kept during busy", v, 'h1357);
    rd(5, v); check("R11 busy reject error", (v >> 1) & 1, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule